// File: doc/BRIEF.md
# Software-Refilled Translation Buffer with Address-Space Tags

This block is a small, fully associative translation buffer for a processor that refills its translations in software. Each entry holds a virtual page number, a physical page number, an address-space tag, a valid flag, a global flag and three access-permission flags: read, write and execute. Software installs an entry or clears it by index through a write port. Software also loads the current address-space tag on every task switch. The hardware never walks page tables. A lookup that finds no entry reports a miss, and the trap handler refills the buffer.

A lookup presents a virtual page number and an access kind. One clock later the block returns a registered result: hit, miss, permission fault, multi-match error, the physical page number and the index of the entry used. Entries with the global flag set ignore the address-space tag, so one entry can serve a kernel page in every process. An entry with no permission flags set is a negative mapping: it matches, and every access through it faults.

A bypass input passes the virtual page number through unchanged and never misses. Exception handlers use it to run on physical addresses. Two invalidate inputs clear either every entry or only the non-global entries in a single cycle.

Top module: `swTlb`

## Requirements
- R1: After reset every entry is invalid, the current tag is 0, and all response outputs are 0. A lookup made right after reset misses.
- R2: A lookup presented with `lkValid` high produces `rspValid` high on the following clock edge. `rspValid` is low in every cycle that follows a cycle without a lookup.
- R3: A non-global entry hits only when it is valid, its page number equals `lkVpn`, and its tag equals the current tag. On a hit `rspPpn` returns the entry's physical page number and `rspIdx` returns its index.
- R4: A valid global entry hits on page number alone, whatever the current tag is.
- R5: Loading a new tag with `asidWe` affects lookups from the next cycle on. A lookup in the same cycle as the load uses the old tag. After the load, non-global entries carrying the old tag stop hitting.
- R6: When no entry matches, `rspMiss` is 1, and `rspHit`, `rspFault`, `rspMulti`, `rspPpn` and `rspIdx` are 0.
- R7: Access codes are 0 for read (permission bit 0), 1 for write (bit 1), 2 for execute (bit 2), and 3, which is reserved and grants nothing. A hit whose permission bit for the access is clear sets `rspFault` together with `rspHit`. An entry with all three permission bits clear faults for every access.
- R8: When more than one entry matches, `rspMulti` is 1, and `rspIdx` and `rspPpn` come from the lowest-index matching entry.
- R9: With `bypass` high, a lookup returns `rspHit`=1 with `rspPpn` equal to `lkVpn`. `rspMiss`, `rspFault`, `rspMulti` and `rspIdx` are all 0 in that case, whatever the entries hold.
- R10: An entry written with `wrEn` at a clock edge is seen by lookups starting in the next cycle. A lookup in the same cycle as the write sees the old contents.
- R11: `invAll` clears the valid flag of every entry, global entries included, in one cycle.
- R12: `invNonGlobal` clears only entries whose global flag is clear. A write to an entry in the same cycle as either invalidate takes precedence for that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request this cycle |
| lkVpn | input | 20 | Virtual page number to translate |
| lkAccess | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| bypass | input | 1 | Pass the address through untranslated |
| asidWe | input | 1 | Load the current address-space tag |
| asidIn | input | 8 | New current tag |
| wrEn | input | 1 | Write one entry |
| wrIdx | input | 4 | Entry index to write |
| wrVpn | input | 20 | Virtual page number for the entry |
| wrPpn | input | 20 | Physical page number for the entry |
| wrAsid | input | 8 | Address-space tag for the entry |
| wrValid | input | 1 | Valid flag (0 invalidates the entry) |
| wrGlobal | input | 1 | Global flag for the entry |
| wrRights | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| invAll | input | 1 | Clear every valid flag |
| invNonGlobal | input | 1 | Clear valid flags of non-global entries |
| rspValid | output | 1 | Registered result available |
| rspHit | output | 1 | Translation found (or bypassed) |
| rspMiss | output | 1 | No entry matched |
| rspFault | output | 1 | Hit, but the access is not permitted |
| rspMulti | output | 1 | More than one entry matched |
| rspPpn | output | 20 | Physical page number |
| rspIdx | output | 4 | Index of the entry used |

## Verification
Lookups are tried against entries that differ in one key field at a time. The page number, the tag and the global flag are each varied alone, so a wrong comparison shows up as a false hit or a false miss. Each access kind is applied to entries with partial, full and empty permission sets, and this separates a permission fault from a miss. A lookup is placed in the same cycle as an entry write, a tag load and each invalidate, and then again one cycle later. These pairs show whether state changes are ordered correctly against lookups. Overlapping entries check the lowest-index choice, and bypass lookups on both mapped and unmapped pages check that translation is fully skipped.

// File: rtl/swTlbPkg.sv
package swTlbPkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_e;

  typedef struct packed {
    logic lookupGo;
    logic entryWe;
    logic clrAll;
    logic clrLocal;
    logic asidLoad;
  } tlbStrobe_t;

  localparam int RIGHT_R = 0;
  localparam int RIGHT_W = 1;
  localparam int RIGHT_X = 2;
endpackage

// File: rtl/swTlbCtrl.sv
module swTlbCtrl
  import swTlbPkg::*;
(
  input  logic       lkValid,
  input  logic       wrEn,
  input  logic       invAll,
  input  logic       invNonGlobal,
  input  logic       asidWe,
  output tlbStrobe_t strobes
);
  always_comb begin
    strobes.lookupGo = lkValid;
    strobes.entryWe  = wrEn;
    strobes.clrAll   = invAll;
    // a full flush already covers the local flush
    strobes.clrLocal = invNonGlobal && !invAll;
    strobes.asidLoad = asidWe;
  end
endmodule

// File: rtl/swTlbDatapath.sv
module swTlbDatapath
  import swTlbPkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int VPN_W       = 20,
  parameter int PPN_W       = 20,
  parameter int ASID_W      = 8,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        st,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [1:0]        lkAccess,
  input  logic              bypass,
  input  logic [ASID_W-1:0] asidIn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [PPN_W-1:0]  wrPpn,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrValid,
  input  logic              wrGlobal,
  input  logic [2:0]        wrRights,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic              rspFault,
  output logic              rspMulti,
  output logic [PPN_W-1:0]  rspPpn,
  output logic [IDX_W-1:0]  rspIdx
);
  logic [NUM_ENTRIES-1:0] validQ;
  logic [NUM_ENTRIES-1:0] globalQ;
  logic [VPN_W-1:0]       vpnQ    [NUM_ENTRIES];
  logic [PPN_W-1:0]       ppnQ    [NUM_ENTRIES];
  logic [ASID_W-1:0]      asidQ   [NUM_ENTRIES];
  logic [2:0]             rightsQ [NUM_ENTRIES];
  logic [ASID_W-1:0]      curAsid;

  // current address-space tag
  always_ff @(posedge clk) begin
    if (!rstN)            curAsid <= '0;
    else if (st.asidLoad) curAsid <= asidIn;
  end

  // valid and global flags: the flush is applied first, the indexed write overrides it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ  <= '0;
      globalQ <= '0;
    end else begin
      if (st.clrAll)        validQ <= '0;
      else if (st.clrLocal) validQ <= validQ & globalQ;
      if (st.entryWe) begin
        validQ[wrIdx]  <= wrValid;
        globalQ[wrIdx] <= wrGlobal;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st.entryWe) begin
      vpnQ[wrIdx]    <= wrVpn;
      ppnQ[wrIdx]    <= wrPpn;
      asidQ[wrIdx]   <= wrAsid;
      rightsQ[wrIdx] <= wrRights;
    end
  end

  // per-entry match
  logic [NUM_ENTRIES-1:0] matchVec;
  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_match
    always_comb
      matchVec[gi] = validQ[gi] && (vpnQ[gi] == lkVpn)
                     && (globalQ[gi] || ~|(asidQ[gi] ^ curAsid));
  end

  // lowest-index priority select
  logic [IDX_W-1:0] selIdx;
  logic             anyHit;
  logic             manyHit;
  always_comb begin
    selIdx  = '0;
    anyHit  = 1'b0;
    manyHit = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (matchVec[i]) begin
        if (anyHit) manyHit = 1'b1;
        else        selIdx  = IDX_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  logic       permitted;
  logic [2:0] selRights;
  always_comb begin
    selRights = rightsQ[selIdx];
    unique case (accKind_e'(lkAccess))
      ACC_READ:  permitted = selRights[RIGHT_R];
      ACC_WRITE: permitted = selRights[RIGHT_W];
      ACC_EXEC:  permitted = selRights[RIGHT_X];
      default:   permitted = 1'b0;
    endcase
  end

  // registered response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspMiss  <= 1'b0;
      rspFault <= 1'b0;
      rspMulti <= 1'b0;
      rspPpn   <= '0;
      rspIdx   <= '0;
    end else begin
      rspValid <= st.lookupGo;
      if (!st.lookupGo) begin
        rspHit   <= 1'b0;
        rspMiss  <= 1'b0;
        rspFault <= 1'b0;
        rspMulti <= 1'b0;
        rspPpn   <= '0;
        rspIdx   <= '0;
      end else if (bypass) begin
        rspHit   <= 1'b1;
        rspMiss  <= 1'b0;
        rspFault <= 1'b0;
        rspMulti <= 1'b0;
        rspPpn   <= PPN_W'(lkVpn);
        rspIdx   <= '0;
      end else begin
        rspHit   <= anyHit;
        rspMiss  <= !anyHit;
        rspFault <= anyHit && !permitted;
        rspMulti <= manyHit;
        rspPpn   <= anyHit ? ppnQ[selIdx] : '0;
        rspIdx   <= anyHit ? selIdx : '0;
      end
    end
  end

  // assertions
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.lookupGo |=> rspValid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !st.lookupGo |=> !rspValid && !rspHit && !rspMiss);
  p_tag_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.asidLoad |=> curAsid == $past(asidIn));
  p_miss_clean_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspMiss |-> !rspHit && !rspFault && !rspMulti && rspPpn == '0);
  p_fault_needs_hit_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> rspHit);
  p_multi_needs_hit_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspMulti |-> rspHit && !rspMiss);
  p_bypass_pass_r9: assert property (@(posedge clk) disable iff (!rstN)
    (st.lookupGo && bypass) |=> rspHit && !rspMiss && !rspFault
                                && rspPpn == PPN_W'($past(lkVpn)));
  p_flush_all_r11: assert property (@(posedge clk) disable iff (!rstN)
    (st.clrAll && !st.entryWe) |=> validQ == '0);
  p_flush_local_r12: assert property (@(posedge clk) disable iff (!rstN)
    (st.clrLocal && !st.entryWe) |=> (validQ & ~globalQ) == '0);
endmodule

// File: rtl/swTlb.sv
module swTlb
  import swTlbPkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int VPN_W       = 20,
  parameter int PPN_W       = 20,
  parameter int ASID_W      = 8,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [1:0]        lkAccess,
  input  logic              bypass,
  input  logic              asidWe,
  input  logic [ASID_W-1:0] asidIn,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [PPN_W-1:0]  wrPpn,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrValid,
  input  logic              wrGlobal,
  input  logic [2:0]        wrRights,
  input  logic              invAll,
  input  logic              invNonGlobal,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic              rspFault,
  output logic              rspMulti,
  output logic [PPN_W-1:0]  rspPpn,
  output logic [IDX_W-1:0]  rspIdx
);
  tlbStrobe_t strobes;

  swTlbCtrl u_ctrl (
    .lkValid      (lkValid),
    .wrEn         (wrEn),
    .invAll       (invAll),
    .invNonGlobal (invNonGlobal),
    .asidWe       (asidWe),
    .strobes      (strobes)
  );

  swTlbDatapath #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .VPN_W       (VPN_W),
    .PPN_W       (PPN_W),
    .ASID_W      (ASID_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (strobes),
    .lkVpn    (lkVpn),
    .lkAccess (lkAccess),
    .bypass   (bypass),
    .asidIn   (asidIn),
    .wrIdx    (wrIdx),
    .wrVpn    (wrVpn),
    .wrPpn    (wrPpn),
    .wrAsid   (wrAsid),
    .wrValid  (wrValid),
    .wrGlobal (wrGlobal),
    .wrRights (wrRights),
    .rspValid (rspValid),
    .rspHit   (rspHit),
    .rspMiss  (rspMiss),
    .rspFault (rspFault),
    .rspMulti (rspMulti),
    .rspPpn   (rspPpn),
    .rspIdx   (rspIdx)
  );
endmodule

// File: tb/swTlb_bench.sv
`timescale 1ns/1ps
module swTlb_bench;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        lkValid = 0, bypass = 0, asidWe = 0, wrEn = 0;
  logic [19:0] lkVpn = '0, wrVpn = '0, wrPpn = '0;
  logic [1:0]  lkAccess = '0;
  logic [7:0]  asidIn = '0, wrAsid = '0;
  logic [3:0]  wrIdx = '0;
  logic        wrValid = 0, wrGlobal = 0, invAll = 0, invNonGlobal = 0;
  logic [2:0]  wrRights = '0;
  logic        rspValid, rspHit, rspMiss, rspFault, rspMulti;
  logic [19:0] rspPpn;
  logic [3:0]  rspIdx;

  swTlb u_swTlb (.*);

  typedef struct {
    logic        hit, miss, fault, multi;
    logic [19:0] ppn;
    logic [3:0]  idx;
    string       tag;
  } expItem_t;

  expItem_t scoreQ[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic        mV[N], mG[N];
  logic [19:0] mVpn[N], mPpn[N];
  logic [7:0]  mAsid[N];
  logic [2:0]  mR[N];
  logic [7:0]  mCur;

  function automatic expItem_t predict(logic [19:0] vpn, logic [1:0] acc, logic byp, string tag);
    expItem_t e;
    int cnt = 0;
    e.hit = 0; e.miss = 0; e.fault = 0; e.multi = 0; e.ppn = '0; e.idx = '0; e.tag = tag;
    if (byp) begin
      e.hit = 1; e.ppn = vpn;
      return e;
    end
    for (int i = 0; i < N; i++) begin
      if (mV[i] && mVpn[i] == vpn && (mG[i] || mAsid[i] == mCur)) begin
        if (cnt == 0) begin
          e.idx = 4'(i); e.ppn = mPpn[i];
          e.fault = (acc == 2'd3) ? 1'b1 : !mR[i][acc];
        end
        cnt++;
      end
    end
    e.hit = cnt > 0; e.miss = cnt == 0; e.multi = cnt > 1;
    return e;
  endfunction

  // pending model updates applied after the clock edge
  bit pWr, pAsid, pAll, pLocal;

  task automatic lookup(logic [19:0] vpn, logic [1:0] acc, logic byp, string tag);
    scoreQ.push_back(predict(vpn, acc, byp, tag));
    lkValid = 1; lkVpn = vpn; lkAccess = acc; bypass = byp;
  endtask

  task automatic writeEnt(int idx, logic [19:0] v, logic [19:0] p, logic [7:0] a,
                          logic val, logic g, logic [2:0] r);
    wrEn = 1; wrIdx = 4'(idx); wrVpn = v; wrPpn = p; wrAsid = a;
    wrValid = val; wrGlobal = g; wrRights = r; pWr = 1;
  endtask

  task automatic setAsid(logic [7:0] a);
    asidWe = 1; asidIn = a; pAsid = 1;
  endtask

  task automatic endCycle;
    @(posedge clk);
    if (pAll) for (int i = 0; i < N; i++) mV[i] = 0;
    else if (pLocal) for (int i = 0; i < N; i++) if (!mG[i]) mV[i] = 0;
    if (pWr) begin
      mV[wrIdx] = wrValid; mG[wrIdx] = wrGlobal; mVpn[wrIdx] = wrVpn;
      mPpn[wrIdx] = wrPpn; mAsid[wrIdx] = wrAsid; mR[wrIdx] = wrRights;
    end
    if (pAsid) mCur = asidIn;
    pWr = 0; pAsid = 0; pAll = 0; pLocal = 0;
    @(negedge clk);
    lkValid = 0; bypass = 0; wrEn = 0; asidWe = 0; invAll = 0; invNonGlobal = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (rspValid) begin
        expItem_t e;
        checks++;
        if (scoreQ.size() == 0) begin
          fails++;
          $display("FAIL R2: rspValid=1 expected 0 (no lookup pending)");
        end else begin
          e = scoreQ.pop_front();
          if ({rspHit, rspMiss, rspFault, rspMulti, rspPpn, rspIdx} !==
              {e.hit, e.miss, e.fault, e.multi, e.ppn, e.idx}) begin
            fails++;
            $display("FAIL %s: hit/miss/fault/multi/ppn/idx = %0b%0b%0b%0b/%h/%0d expected %0b%0b%0b%0b/%h/%0d",
                     e.tag, rspHit, rspMiss, rspFault, rspMulti, rspPpn, rspIdx,
                     e.hit, e.miss, e.fault, e.multi, e.ppn, e.idx);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mV[i] = 0; mG[i] = 0; mVpn[i] = '0; mPpn[i] = '0; mAsid[i] = '0; mR[i] = '0;
    end
    mCur = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1: reset state of outputs
    checks++;
    if ({rspValid, rspHit, rspMiss, rspFault, rspMulti, rspPpn, rspIdx} !== '0) begin
      fails++;
      $display("FAIL R1: outputs %b expected all zero",
               {rspValid, rspHit, rspMiss, rspFault, rspMulti, rspPpn, rspIdx});
    end
    lookup(20'h00000, 2'd0, 0, "R1 post-reset miss"); endCycle;

    // R3: non-global entry, tag mismatch then match
    writeEnt(0, 20'h12345, 20'hABCDE, 8'h05, 1, 0, 3'b011); endCycle;
    lookup(20'h12345, 2'd0, 0, "R3 tag mismatch miss"); endCycle;
    setAsid(8'h05); endCycle;
    lookup(20'h12345, 2'd0, 0, "R3 read hit"); endCycle;
    lookup(20'h12346, 2'd0, 0, "R3 vpn differs miss"); endCycle;
    lookup(20'h12345, 2'd1, 0, "R7 write permitted"); endCycle;
    lookup(20'h12345, 2'd2, 0, "R7 exec fault"); endCycle;
    lookup(20'h12345, 2'd3, 0, "R7 reserved access fault"); endCycle;

    // R4: global entry
    writeEnt(3, 20'h00100, 20'h80100, 8'h33, 1, 1, 3'b100); endCycle;
    lookup(20'h00100, 2'd2, 0, "R4 global hit tag5"); endCycle;
    // R5: same-cycle tag load uses old tag
    setAsid(8'h09);
    lookup(20'h12345, 2'd0, 0, "R5 same-cycle old tag"); endCycle;
    lookup(20'h12345, 2'd0, 0, "R5 old tag stops hitting"); endCycle;
    lookup(20'h00100, 2'd0, 0, "R4 global hit tag9 read fault"); endCycle;

    // R7: negative mapping
    writeEnt(5, 20'h00555, 20'h11111, 8'h09, 1, 0, 3'b000); endCycle;
    lookup(20'h00555, 2'd0, 0, "R7 negative read"); endCycle;
    lookup(20'h00555, 2'd2, 0, "R7 negative exec"); endCycle;

    // R8: multi-hit, lowest index wins
    writeEnt(10, 20'h00777, 20'h0AAAA, 8'h00, 1, 1, 3'b111); endCycle;
    writeEnt(7,  20'h00777, 20'h07777, 8'h09, 1, 0, 3'b001); endCycle;
    lookup(20'h00777, 2'd0, 0, "R8 multi lowest index"); endCycle;
    lookup(20'h00777, 2'd1, 0, "R8 multi fault from lowest"); endCycle;

    // R9: bypass
    lookup(20'h00555, 2'd0, 1, "R9 bypass mapped page"); endCycle;
    lookup(20'hFEDCB, 2'd3, 1, "R9 bypass unmapped page"); endCycle;

    // R10: write and lookup in same cycle, then back-to-back lookups
    writeEnt(12, 20'h0C0C0, 20'h5A5A5, 8'h09, 1, 0, 3'b111);
    lookup(20'h0C0C0, 2'd0, 0, "R10 same-cycle old contents"); endCycle;
    lookup(20'h0C0C0, 2'd1, 0, "R10 next-cycle hit"); endCycle;
    writeEnt(12, 20'h0C0C0, 20'h5A5A5, 8'h09, 0, 0, 3'b111);
    lookup(20'h0C0C0, 2'd2, 0, "R10 invalidating write same cycle"); endCycle;
    lookup(20'h0C0C0, 2'd2, 0, "R10 invalidated entry misses"); endCycle;

    // R12: local flush, write wins for its index
    writeEnt(12, 20'h0C0C0, 20'h5A5A5, 8'h09, 1, 0, 3'b111); endCycle;
    invNonGlobal = 1; pLocal = 1;
    writeEnt(1, 20'h00ABC, 20'h00DEF, 8'h09, 1, 0, 3'b001); endCycle;
    lookup(20'h0C0C0, 2'd0, 0, "R12 local entry cleared"); endCycle;
    lookup(20'h00100, 2'd2, 0, "R12 global entry kept"); endCycle;
    lookup(20'h00ABC, 2'd0, 0, "R12 same-cycle write survives"); endCycle;
    lookup(20'h00777, 2'd0, 0, "R12 global survivor single hit"); endCycle;

    // R11: full flush
    invAll = 1; pAll = 1; endCycle;
    lookup(20'h00100, 2'd2, 0, "R11 global entry cleared"); endCycle;
    lookup(20'h00ABC, 2'd0, 0, "R11 local entry cleared"); endCycle;

    repeat (3) @(negedge clk);
    checks++;
    if (scoreQ.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d responses missing, expected 0", scoreQ.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule